// File: doc/BRIEF.md
# Depth-First Configuration Hierarchy Walker

This block is a hardware requester that discovers a tree of configuration-addressed functions on its own. After a start pulse it walks the hierarchy depth-first from bus 0. On every bus it probes the device slots, and the extra function slots of multi-function devices. It recognises bridges by their base class byte. Each bridge gets bus numbers as the walk goes down: primary, secondary and subordinate are written as one dword. Bus numbers come from a running counter of the highest bus assigned so far.

Every access uses a simple dword handshake: one request at a time, held until the responder acknowledges it. When the walk enters a bridge, it saves its position in a small RAM-backed stack and moves to the new bus. When that subtree is finished, it pops the position back and rewrites the bridge's subordinate number with the real upper bound. The walk stops when bus 0 is exhausted. A one-cycle done pulse then presents the number of functions found and the highest bus number assigned. A flag reports whether any bridge was skipped because the stack was full.

Top module: `busenum_engine`

## Requirements
- R1: After reset, done, depth_err and cfg_req are low, and func_count and last_bus are zero.
- R2: A request holds cfg_req high with we, bus, dev, fn, reg and wdata unchanged until the cycle cfg_ack is seen. Only one access is outstanding at any time.
- R3: On every bus, device slots 0 through 31 are probed by reading dword 0 of function 0. A vendor field (bits 15:0) of 0xFFFF marks the slot as empty, and the walk moves on to the next device without touching its other functions.
- R4: Functions 1 to 7 of a device are probed only when function 0 is present and bit 7 of its header type byte (dword 3, bits 23:16) is set. An empty function is skipped on its own.
- R5: A present function whose base class byte (dword 2, bits 31:24) equals 0x06 is a bridge. The walk descends into it at once, before the remaining slots of the current bus. Secondary numbers are therefore handed out in discovery order.
- R6: On entering a bridge, one write to dword 6 carries the current bus in bits 7:0 and the next unused bus number in bits 15:8. Bits 23:16 carry 0xFF and bits 31:24 carry zero.
- R7: When a bridge's subtree is finished, dword 6 is written again with bits 23:16 set to the highest bus number assigned beneath it. If the subtree held no bridge, this value equals its secondary number.
- R8: No bus number above 255 is ever assigned. Once 255 has been given out, later bridges are counted as functions but are neither written nor entered.
- R9: Nesting is limited to STACK_DEPTH levels. A bridge found at full depth is counted but neither written nor entered, and depth_err is reported high with done.
- R10: When the scan of bus 0 ends, done is high for exactly one cycle. At that point func_count holds the number of present functions, bridges included, and last_bus holds the highest bus number assigned. Both stay valid until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a walk when idle |
| cfg_req | output | 1 | Access request, held until acknowledged |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword index |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | One-cycle acknowledge of the current request |
| cfg_rdata | input | 32 | Read data, valid with cfg_ack |
| done | output | 1 | One-cycle completion pulse |
| func_count | output | CNT_W | Functions found in the last walk |
| last_bus | output | 8 | Highest bus number assigned |
| depth_err | output | 1 | A bridge was skipped at full stack depth |

## Verification
The assertions assume a responder that raises cfg_ack for exactly one cycle, only while cfg_req is high, with cfg_rdata valid in that cycle. They also assume the hierarchy is a tree, so each secondary bus leads to exactly one subtree. The bench responder answers only pending requests and drops the acknowledge after a single cycle. It inserts a varying wait of zero to two cycles, which makes the request-hold rule matter. It maps each bus number to a subtree only once the walker has written that bridge's secondary number. Reads of unmapped buses return all ones, which keeps the stimulus inside those assumptions.

// File: rtl/busenum_pkg.sv
package busenum_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 6;
  localparam int DW    = 32;

  localparam logic [15:0]      NO_VENDOR    = 16'hFFFF;
  localparam logic [7:0]       BRIDGE_CLASS = 8'h06;
  localparam logic [7:0]       SUB_OPEN     = 8'hFF;
  localparam logic [REG_W-1:0] REG_IDENT    = 6'd0;
  localparam logic [REG_W-1:0] REG_CLASS    = 6'd2;
  localparam logic [REG_W-1:0] REG_HDR      = 6'd3;
  localparam logic [REG_W-1:0] REG_BUSNUM   = 6'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_HDR, S_CLASS, S_OPEN,
    S_NEXT_FN, S_NEXT_DEV, S_END_BUS, S_POP, S_CLOSE
  } walk_state_t;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic             multi;
    logic [BUS_W-1:0] sec;
  } frame_t;
endpackage

// File: rtl/busenum_stack.sv
module busenum_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 25,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/busenum_cfg_port.sv
module busenum_cfg_port
  import busenum_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             iss_we,
  input  logic [BUS_W-1:0] iss_bus,
  input  logic [DEV_W-1:0] iss_dev,
  input  logic [FN_W-1:0]  iss_fn,
  input  logic [REG_W-1:0] iss_reg,
  input  logic [DW-1:0]    iss_wdata,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [BUS_W-1:0] cfg_bus,
  output logic [DEV_W-1:0] cfg_dev,
  output logic [FN_W-1:0]  cfg_fn,
  output logic [REG_W-1:0] cfg_reg,
  output logic [DW-1:0]    cfg_wdata,
  input  logic             cfg_ack,
  input  logic [DW-1:0]    cfg_rdata,
  output logic             resp_valid,
  output logic             resp_absent,
  output logic             resp_multi,
  output logic             resp_bridge
);
  logic unused_rdata_bits;
  assign unused_rdata_bits = ^cfg_rdata[22:16];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_req     <= 1'b0;
      cfg_we      <= 1'b0;
      cfg_bus     <= '0;
      cfg_dev     <= '0;
      cfg_fn      <= '0;
      cfg_reg     <= '0;
      cfg_wdata   <= '0;
      resp_valid  <= 1'b0;
      resp_absent <= 1'b0;
      resp_multi  <= 1'b0;
      resp_bridge <= 1'b0;
    end else begin
      resp_valid <= cfg_req && cfg_ack;
      if (cfg_req && cfg_ack) begin
        cfg_req     <= 1'b0;
        resp_absent <= (cfg_rdata[15:0] == NO_VENDOR);
        resp_multi  <= cfg_rdata[23];
        resp_bridge <= (cfg_rdata[31:24] == BRIDGE_CLASS);
      end else if (issue) begin
        cfg_req   <= 1'b1;
        cfg_we    <= iss_we;
        cfg_bus   <= iss_bus;
        cfg_dev   <= iss_dev;
        cfg_fn    <= iss_fn;
        cfg_reg   <= iss_reg;
        cfg_wdata <= iss_wdata;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_we) && $stable(cfg_bus) && $stable(cfg_dev)
      && $stable(cfg_fn) && $stable(cfg_reg) && $stable(cfg_wdata)); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    issue |-> !cfg_req && !resp_valid); // R2
endmodule

// File: rtl/busenum_engine.sv
module busenum_engine
  import busenum_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int CNT_W       = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [BUS_W-1:0] cfg_bus,
  output logic [DEV_W-1:0] cfg_dev,
  output logic [FN_W-1:0]  cfg_fn,
  output logic [REG_W-1:0] cfg_reg,
  output logic [DW-1:0]    cfg_wdata,
  input  logic             cfg_ack,
  input  logic [DW-1:0]    cfg_rdata,
  output logic             done,
  output logic [CNT_W-1:0] func_count,
  output logic [BUS_W-1:0] last_bus,
  output logic             depth_err
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);
  localparam int AW   = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int FW   = $bits(frame_t);
  localparam logic [DEV_W-1:0] DEV_LAST = '1;
  localparam logic [FN_W-1:0]  FN_LAST  = '1;
  localparam logic [BUS_W-1:0] BUS_MAX  = '1;
  localparam logic [SP_W-1:0]  SP_FULL  = SP_W'(STACK_DEPTH);

  walk_state_t      state;
  logic [BUS_W-1:0] cur_bus, top_bus, cur_sec;
  logic [DEV_W-1:0] cur_dev;
  logic [FN_W-1:0]  cur_fn;
  logic             cur_multi, launched, derr;
  logic [SP_W-1:0]  sp;
  logic [CNT_W-1:0] count;

  logic             issue, iss_we;
  logic [REG_W-1:0] iss_reg;
  logic [DW-1:0]    iss_wdata;
  logic             resp_valid, resp_absent, resp_multi, resp_bridge;
  logic             push;
  frame_t           push_frame, pop_frame;
  logic [FW-1:0]    pop_bits;
  logic [BUS_W-1:0] next_bus;

  assign next_bus  = top_bus + 8'd1;
  assign pop_frame = frame_t'(pop_bits);

  always_comb begin
    issue     = 1'b0;
    iss_we    = 1'b0;
    iss_reg   = REG_IDENT;
    iss_wdata = '0;
    case (state)
      S_PROBE: begin issue = !launched; iss_reg = REG_IDENT; end
      S_HDR:   begin issue = !launched; iss_reg = REG_HDR;   end
      S_CLASS: begin issue = !launched; iss_reg = REG_CLASS; end
      S_OPEN: begin
        issue     = !launched;
        iss_we    = 1'b1;
        iss_reg   = REG_BUSNUM;
        iss_wdata = {8'h00, SUB_OPEN, next_bus, cur_bus};
      end
      S_CLOSE: begin
        issue     = !launched;
        iss_we    = 1'b1;
        iss_reg   = REG_BUSNUM;
        iss_wdata = {8'h00, top_bus, cur_sec, cur_bus};
      end
      default: ;
    endcase
  end

  assign push       = (state == S_OPEN) && resp_valid;
  assign push_frame = '{bus: cur_bus, dev: cur_dev, fn: cur_fn, multi: cur_multi, sec: next_bus};

  busenum_cfg_port u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .iss_we     (iss_we),
    .iss_bus    (cur_bus),
    .iss_dev    (cur_dev),
    .iss_fn     (cur_fn),
    .iss_reg    (iss_reg),
    .iss_wdata  (iss_wdata),
    .cfg_req    (cfg_req),
    .cfg_we     (cfg_we),
    .cfg_bus    (cfg_bus),
    .cfg_dev    (cfg_dev),
    .cfg_fn     (cfg_fn),
    .cfg_reg    (cfg_reg),
    .cfg_wdata  (cfg_wdata),
    .cfg_ack    (cfg_ack),
    .cfg_rdata  (cfg_rdata),
    .resp_valid (resp_valid),
    .resp_absent(resp_absent),
    .resp_multi (resp_multi),
    .resp_bridge(resp_bridge)
  );

  busenum_stack #(.DEPTH(STACK_DEPTH), .W(FW)) u_stack (
    .clk    (clk),
    .wr_en  (push),
    .wr_addr(AW'(sp)),
    .wr_data(push_frame),
    .rd_addr(AW'(sp - SP_W'(1))),
    .rd_data(pop_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cur_bus    <= '0;
      cur_dev    <= '0;
      cur_fn     <= '0;
      cur_multi  <= 1'b0;
      cur_sec    <= '0;
      top_bus    <= '0;
      sp         <= '0;
      count      <= '0;
      launched   <= 1'b0;
      derr       <= 1'b0;
      done       <= 1'b0;
      func_count <= '0;
      last_bus   <= '0;
      depth_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (issue) launched <= 1'b1;
      if (resp_valid) launched <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur_bus   <= '0;
          cur_dev   <= '0;
          cur_fn    <= '0;
          cur_multi <= 1'b0;
          top_bus   <= '0;
          sp        <= '0;
          count     <= '0;
          derr      <= 1'b0;
          state     <= S_PROBE;
        end
        S_PROBE: if (resp_valid) begin
          if (resp_absent) begin
            state <= (cur_fn == '0) ? S_NEXT_DEV : S_NEXT_FN;
          end else begin
            count <= count + 1'b1;
            state <= S_HDR;
          end
        end
        S_HDR: if (resp_valid) begin
          if (cur_fn == '0) cur_multi <= resp_multi;
          state <= S_CLASS;
        end
        S_CLASS: if (resp_valid) begin
          if (!resp_bridge || top_bus == BUS_MAX) begin
            state <= S_NEXT_FN;
          end else if (sp == SP_FULL) begin
            derr  <= 1'b1;
            state <= S_NEXT_FN;
          end else begin
            state <= S_OPEN;
          end
        end
        S_OPEN: if (resp_valid) begin
          sp        <= sp + 1'b1;
          top_bus   <= next_bus;
          cur_bus   <= next_bus;
          cur_dev   <= '0;
          cur_fn    <= '0;
          cur_multi <= 1'b0;
          state     <= S_PROBE;
        end
        S_NEXT_FN: begin
          if (!cur_multi || cur_fn == FN_LAST) begin
            state <= S_NEXT_DEV;
          end else begin
            cur_fn <= cur_fn + 1'b1;
            state  <= S_PROBE;
          end
        end
        S_NEXT_DEV: begin
          cur_fn    <= '0;
          cur_multi <= 1'b0;
          if (cur_dev == DEV_LAST) begin
            state <= S_END_BUS;
          end else begin
            cur_dev <= cur_dev + 1'b1;
            state   <= S_PROBE;
          end
        end
        S_END_BUS: begin
          if (sp == '0) begin
            done       <= 1'b1;
            func_count <= count;
            last_bus   <= top_bus;
            depth_err  <= derr;
            state      <= S_IDLE;
          end else begin
            sp    <= sp - 1'b1;
            state <= S_POP;
          end
        end
        S_POP: begin
          cur_bus   <= pop_frame.bus;
          cur_dev   <= pop_frame.dev;
          cur_fn    <= pop_frame.fn;
          cur_multi <= pop_frame.multi;
          cur_sec   <= pop_frame.sec;
          state     <= S_CLOSE;
        end
        S_CLOSE: if (resp_valid) state <= S_NEXT_FN;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (rst)
    sp <= SP_FULL); // R9
  AST_WR_TARGET: assert property (@(posedge clk) disable iff (rst)
    cfg_req && cfg_we |-> cfg_reg == REG_BUSNUM && cfg_wdata[31:24] == 8'h00); // R6
  AST_BUS_ORDER: assert property (@(posedge clk) disable iff (rst)
    cfg_req && cfg_we |-> cfg_wdata[15:8] > cfg_wdata[7:0] && cfg_wdata[23:16] >= cfg_wdata[15:8]); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE |-> !launched); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    state == S_OPEN |-> top_bus != BUS_MAX); // R8
endmodule

// File: tb/busenum_engine_bench.sv
module busenum_engine_bench;
  import busenum_pkg::*;

  localparam int DEPTH = 2;
  localparam int CW    = 17;
  localparam int NE    = 17;
  localparam int NV    = 5;
  localparam int WIDE  = 4;
  localparam int WBASE = 64;
  localparam int NSLOT = WBASE + 256;

  typedef struct packed {
    logic [3:0] scen;
    logic [3:0] seg;
    logic [4:0] dev;
    logic [2:0] fn;
    logic       mf;
    logic       br;
    logic [3:0] child;
    logic [7:0] pri;
    logic [7:0] sec;
    logic [7:0] sub;
  } ent_t;

  // pri == 8'hEE marks a bridge that must never be written
  localparam ent_t TBL [NE] = '{
    '{4'd0, 4'd0, 5'd0,  3'd0, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd1, 4'd0, 5'd3,  3'd0, 1'b1, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd1, 4'd0, 5'd3,  3'd2, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd1, 4'd0, 5'd3,  3'd7, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd1, 4'd0, 5'd5,  3'd0, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd1, 4'd0, 5'd5,  3'd1, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd1, 4'd0, 5'd7,  3'd1, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd2, 4'd0, 5'd1,  3'd0, 1'b0, 1'b1, 4'd1, 8'd0, 8'd1, 8'd2},
    '{4'd2, 4'd0, 5'd2,  3'd0, 1'b0, 1'b1, 4'd2, 8'd0, 8'd3, 8'd3},
    '{4'd2, 4'd1, 5'd0,  3'd0, 1'b0, 1'b1, 4'd3, 8'd1, 8'd2, 8'd2},
    '{4'd2, 4'd1, 5'd4,  3'd0, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd2, 4'd3, 5'd0,  3'd0, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd2, 4'd2, 5'd31, 3'd0, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0},
    '{4'd3, 4'd0, 5'd0,  3'd0, 1'b0, 1'b1, 4'd1, 8'd0, 8'd1, 8'd2},
    '{4'd3, 4'd1, 5'd0,  3'd0, 1'b0, 1'b1, 4'd2, 8'd1, 8'd2, 8'd2},
    '{4'd3, 4'd2, 5'd0,  3'd0, 1'b0, 1'b1, 4'd3, 8'hEE, 8'd0, 8'd0},
    '{4'd3, 4'd2, 5'd1,  3'd0, 1'b0, 1'b0, 4'd0, 8'd0, 8'd0, 8'd0}
  };

  typedef struct packed {
    logic [3:0]    scen;
    logic [CW-1:0] cnt;
    logic [7:0]    maxb;
    logic          ovf;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd0, 17'd1,   8'd0,   1'b0},
    '{4'd1, 17'd4,   8'd0,   1'b0},
    '{4'd2, 17'd6,   8'd3,   1'b0},
    '{4'd3, 17'd4,   8'd2,   1'b1},
    '{4'd4, 17'd256, 8'd255, 1'b0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, cfg_req, cfg_we, cfg_ack, done, depth_err;
  logic [7:0] cfg_bus, last_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;
  logic [5:0] cfg_reg;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [CW-1:0] func_count;

  busenum_engine #(.STACK_DEPTH(DEPTH), .CNT_W(CW)) u_busenum_engine (
    .clk(clk), .rst(rst), .start(start),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
    .done(done), .func_count(func_count), .last_bus(last_bus), .depth_err(depth_err)
  );

  int n_tests = 0, n_fail = 0, hold_viol = 0, acc_n = 0, cur_scen = 0;
  int wr_n [NSLOT];
  logic [7:0] lp [NSLOT], ls [NSLOT], lb [NSLOT], fsub [NSLOT];
  int bus_seg [256];
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int locate(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f);
    int seg;
    if (cur_scen == WIDE) return (b == 8'd0) ? WBASE + int'(d) * 8 + int'(f) : -1;
    seg = bus_seg[b];
    if (seg < 0) return -1;
    for (int i = 0; i < NE; i++)
      if (int'(TBL[i].scen) == cur_scen && int'(TBL[i].seg) == seg && TBL[i].dev == d && TBL[i].fn == f)
        return i;
    return -1;
  endfunction

  function automatic logic [31:0] model_rd(input int idx, input logic [5:0] r);
    logic mf, br;
    if (idx < 0) return 32'hFFFF_FFFF;
    if (idx >= WBASE) begin mf = 1'b1; br = 1'b1; end
    else begin mf = TBL[idx].mf; br = TBL[idx].br; end
    case (r)
      6'd0: return 32'h5A5A_1234;
      6'd2: return {(br ? 8'h06 : 8'h02), 24'h0};
      6'd3: return {8'h00, mf, 6'h0, br, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input int idx, input logic [31:0] w);
    if (idx < 0) return;
    if (wr_n[idx] == 0) fsub[idx] = w[23:16];
    wr_n[idx]++;
    lp[idx] = w[7:0];
    ls[idx] = w[15:8];
    lb[idx] = w[23:16];
    if (idx < WBASE && TBL[idx].br) bus_seg[w[15:8]] = int'(TBL[idx].child);
  endtask

  task automatic clear_model();
    for (int i = 0; i < NSLOT; i++) begin
      wr_n[i] = 0; lp[i] = 0; ls[i] = 0; lb[i] = 0; fsub[i] = 0;
    end
    for (int i = 0; i < 256; i++) bus_seg[i] = -1;
    bus_seg[0] = 0;
  endtask

  // responder: variable wait, one-cycle acknowledge, hold monitor
  initial begin
    int lat_cnt;
    logic pend;
    logic [22:0] held;
    int idx;
    lat_cnt = 0; pend = 1'b0; held = '0;
    cfg_ack = 1'b0; cfg_rdata = '0;
    forever begin
      @(negedge clk);
      if (pend && (!cfg_req || {cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_reg} != held)) hold_viol++;
      if (cfg_ack) begin
        cfg_ack = 1'b0; pend = 1'b0;
      end else if (cfg_req) begin
        if (lat_cnt < acc_n % 3) begin
          lat_cnt++; pend = 1'b1; held = {cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_reg};
        end else begin
          idx = locate(cfg_bus, cfg_dev, cfg_fn);
          cfg_rdata = cfg_we ? 32'h0 : model_rd(idx, cfg_reg);
          if (cfg_we) model_wr(idx, cfg_wdata);
          cfg_ack = 1'b1; acc_n++; lat_cnt = 0; pend = 1'b0;
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_walk(output bit seen);
    seen = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int c = 0; c < 120000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic check_bridges(input int scen);
    for (int i = 0; i < NE; i++) begin
      if (int'(TBL[i].scen) == scen && TBL[i].br) begin
        if (TBL[i].pri == 8'hEE) begin
          check(wr_n[i] == 0, "R9 skipped bridge written", wr_n[i], 0);
        end else begin
          check(wr_n[i] == 2, "R6 bridge write count", wr_n[i], 2);
          check(fsub[i] == 8'hFF, "R6 subordinate opened", fsub[i], 8'hFF);
          check({lp[i], ls[i]} == {TBL[i].pri, TBL[i].sec}, "R5 primary/secondary",
                {lp[i], ls[i]}, {TBL[i].pri, TBL[i].sec});
          check(lb[i] == TBL[i].sub, "R7 final subordinate", lb[i], TBL[i].sub);
        end
      end
    end
  endtask

  initial begin
    bit seen;
    clear_model();
    do_reset();
    check(!cfg_req && !done && !depth_err, "R1 control outputs", {cfg_req, done, depth_err}, 0);
    check(func_count == 0, "R1 func_count", func_count, 0);
    check(last_bus == 0, "R1 last_bus", last_bus, 0);

    for (int v = 0; v < NV; v++) begin
      cur_scen = int'(VEC[v].scen);
      clear_model();
      do_reset();
      run_walk(seen);
      check(seen, "R10 done seen", seen, 1);
      check(func_count == VEC[v].cnt, "R10 R3 R4 function count", func_count, VEC[v].cnt);
      check(last_bus == VEC[v].maxb, "R10 highest bus", last_bus, VEC[v].maxb);
      check(depth_err == VEC[v].ovf, "R9 depth flag", depth_err, VEC[v].ovf);
      @(negedge clk);
      check(!done, "R10 done one cycle", done, 0);
      check(func_count == VEC[v].cnt, "R10 count held", func_count, VEC[v].cnt);
      if (cur_scen != WIDE) check_bridges(cur_scen);
    end

    // bus-number limit on the wide bus (scenario 4 state still in the model)
    check(ls[WBASE + 31*8 + 6] == 8'd255 && lb[WBASE + 31*8 + 6] == 8'd255,
          "R8 last numbered bridge", {ls[WBASE + 31*8 + 6], lb[WBASE + 31*8 + 6]}, 16'hFFFF);
    check(wr_n[WBASE + 31*8 + 7] == 0, "R8 bridge beyond 255 untouched", wr_n[WBASE + 31*8 + 7], 0);
    check(lp[WBASE] == 0 && ls[WBASE] == 1 && lb[WBASE] == 1, "R7 empty subtree sub=sec",
          {lp[WBASE], ls[WBASE], lb[WBASE]}, 24'h000101);
    check(hold_viol == 0, "R2 request held until ack", hold_viol, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule